// File: doc/BRIEF.md
# Multi-Buffer DMA Channel Sequencer

This block steers one DMA channel through a transfer made of one or more buffers. It keeps a working source address, a working destination address and a per-buffer beat count. For every beat it raises a request with both addresses toward an external data mover and waits for an acknowledge. When a buffer's count runs out, the sequencer decides whether the transfer is over and, if it is not, how each side's address for the next buffer is formed.

Each side picks one of three next-buffer methods on its own. Contiguous continuation keeps the address where the previous buffer stopped. Replay returns to the programmed start address. Chaining takes the address from a four-word descriptor in memory. If either side chains, a descriptor is fetched through a simple read port before every buffer. The descriptor also supplies the buffer length, a last flag and the pointer to the next descriptor. Without chaining, the transfer runs for a programmed number of buffers. When the transfer ends, a one-cycle interrupt pulse tells software that it may reprogram the channel.

Configuration uses word-indexed register writes: 0 source start, 1 destination start, 2 buffer length in beats (bits 15:0), 3 first descriptor pointer, 4 mode, 5 start (bit 0). The mode word holds the source method in bits 1:0, the destination method in bits 3:2 and the buffer count in bits 15:8. Method codes are 0 contiguous, 1 replay, 2 chain, and 3 contiguous.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, and whenever busy is low, busy, irq, beat_req and rd_req are all low.
- R2: A write of 1 in bit 0 to register 5 while idle starts a transfer. busy is high from the next cycle until the transfer has ended.
- R3: Every configuration write made while busy is high is ignored, a start write included: the running transfer and any later transfer started without reprogramming behave as if the write never happened.
- R4: beat_req holds beat_src and beat_dst steady until beat_ack. Each accepted beat advances both addresses by 4. A buffer is made of exactly its length in accepted beats.
- R5: A side in contiguous mode (code 0 or 3) starts each new buffer at the address that follows the last beat of the previous buffer.
- R6: A side in replay mode (code 1) starts each new buffer at its programmed start address. Without chaining, each buffer's length is the programmed length.
- R7: Without chaining on either side, the transfer ends after the number of buffers in mode bits 15:8. A count of 0 or 1 gives a single-buffer transfer.
- R8: When either side chains, a four-word descriptor is read before every buffer, at pointer, pointer+4, pointer+8 and pointer+12, in that order. The words are: source address, destination address, control (length in bits 15:0, last flag in bit 31), and next pointer. rd_req holds rd_addr steady until rd_ack, and rd_req and beat_req are never high together.
- R9: A chaining side takes each buffer's start address from the descriptor, while the other side follows its own method, independently.
- R10: A chained transfer ends after the buffer whose descriptor has the last flag set or a next pointer of zero. Otherwise the next descriptor is read at the next pointer.
- R11: At the end of a transfer, irq is high for exactly one cycle, and busy is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | AW | Configuration write data |
| busy | output | 1 | Transfer in progress |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | AW | Descriptor word byte address |
| rd_ack | input | 1 | Read accepted, rd_data valid |
| rd_data | input | AW | Descriptor word read data |
| beat_req | output | 1 | Beat request toward the data mover |
| beat_src | output | AW | Source byte address of the beat |
| beat_dst | output | AW | Destination byte address of the beat |
| beat_ack | input | 1 | Beat accepted |
| irq | output | 1 | One-cycle transfer-complete pulse |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 16-bit length field and an 8-bit buffer count. Buffer lengths of one to four beats and buffer counts of zero to three keep every buffer boundary, replay restart and descriptor refetch within a few dozen cycles. The read acknowledge and beat acknowledge are withheld on a fixed rhythm, so that the hold rules are exercised on both handshakes. Chains of one to three descriptors cover both ways a chain can end, and also cover mixes of chaining with replay and with contiguous continuation on the other side.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RUN   = 3'd2,
    ST_NEXT  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

  localparam logic [1:0] NB_CONTIG = 2'd0;
  localparam logic [1:0] NB_REPLAY = 2'd1;
  localparam logic [1:0] NB_CHAIN  = 2'd2;

  function automatic logic mode_is_chain(input logic [1:0] m);
    return m == NB_CHAIN;
  endfunction

  function automatic logic mode_is_replay(input logic [1:0] m);
    return m == NB_REPLAY;
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [AW-1:0] wdata,
  input  logic          busy,
  output logic [AW-1:0] src0,
  output logic [AW-1:0] dst0,
  output logic [LW-1:0] len0,
  output logic [AW-1:0] dptr0,
  output logic [1:0]    msrc,
  output logic [1:0]    mdst,
  output logic [CW-1:0] nbuf,
  output logic          start
);
  localparam int NB_LSB = 8;

  logic wr_ok;
  assign wr_ok = we && !busy;
  assign start = wr_ok && (addr == 3'd5) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src0  <= '0;
      dst0  <= '0;
      len0  <= '0;
      dptr0 <= '0;
      msrc  <= '0;
      mdst  <= '0;
      nbuf  <= '0;
    end else if (wr_ok) begin
      case (addr)
        3'd0: src0  <= wdata;
        3'd1: dst0  <= wdata;
        3'd2: len0  <= wdata[LW-1:0];
        3'd3: dptr0 <= wdata;
        3'd4: begin
          msrc <= wdata[1:0];
          mdst <= wdata[3:2];
          nbuf <= wdata[NB_LSB+CW-1:NB_LSB];
        end
        default: ;
      endcase
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(src0) && $stable(dst0) && $stable(len0) && $stable(dptr0)
             && $stable(msrc) && $stable(mdst) && $stable(nbuf)); // R3

endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] init_addr,
  input  logic          load_init,
  input  logic          desc_hit,
  input  logic [AW-1:0] desc_word,
  input  logic          step,
  input  logic          buf_adv,
  output logic [AW-1:0] cur
);
  function automatic logic [AW-1:0] after_buffer(input logic [1:0] m,
                                                 input logic [AW-1:0] here,
                                                 input logic [AW-1:0] origin);
    return mode_is_replay(m) ? origin : here;
  endfunction

  function automatic logic [AW-1:0] beat_advance(input logic [AW-1:0] a);
    return a + AW'(STEP);
  endfunction

  logic take_desc;
  assign take_desc = desc_hit && mode_is_chain(mode);

  always_ff @(posedge clk) begin
    if (!rst_n)          cur <= '0;
    else if (load_init)  cur <= init_addr;
    else if (take_desc)  cur <= desc_word;
    else if (step)       cur <= beat_advance(cur);
    else if (buf_adv)    cur <= after_buffer(mode, cur, init_addr);
  end

  AST_REPLAY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_adv && !load_init && !take_desc && !step && mode_is_replay(mode))
      |=> cur == $past(init_addr)); // R6

  AST_CHAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_desc && !load_init) |=> cur == $past(desc_word)); // R9

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int CW         = 8,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [AW-1:0] rd_data,
  output logic          beat_req,
  output logic [AW-1:0] beat_src,
  output logic [AW-1:0] beat_dst,
  input  logic          beat_ack,
  output logic          irq
);
  localparam int NSIDE = 2;
  localparam int DESC_WORDS = 4;
  localparam int FIW = $clog2(DESC_WORDS);

  seq_state_e     state;
  logic [FIW-1:0] fidx;
  logic [LW-1:0]  remain;
  logic [CW-1:0]  bufs_done;
  logic [AW-1:0]  fptr, d_next;
  logic           d_last;

  logic [AW-1:0] src0, dst0, dptr0;
  logic [LW-1:0] len0;
  logic [1:0]    msrc, mdst;
  logic [CW-1:0] nbuf;
  logic          start;

  dma_cfg_regs #(.AW(AW), .LW(LW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .busy(busy), .src0(src0), .dst0(dst0), .len0(len0), .dptr0(dptr0),
    .msrc(msrc), .mdst(mdst), .nbuf(nbuf), .start(start)
  );

  function automatic logic [AW-1:0] desc_word_addr(input logic [AW-1:0] base,
                                                   input logic [FIW-1:0] idx);
    return base + AW'({idx, 2'b00});
  endfunction

  function automatic logic [CW:0] eff_count(input logic [CW-1:0] n);
    return (n == '0) ? (CW+1)'(1) : {1'b0, n};
  endfunction

  // named internal events
  logic rd_fire, beat_fire, chain_any, last_buf, buf_adv, buf_end;
  assign rd_fire   = rd_req && rd_ack;
  assign beat_fire = beat_req && beat_ack;
  assign chain_any = mode_is_chain(msrc) || mode_is_chain(mdst);
  assign last_buf  = chain_any ? (d_last || (d_next == '0))
                               : (({1'b0, bufs_done} + (CW+1)'(1)) >= eff_count(nbuf));
  assign buf_end   = (state == ST_NEXT);
  assign buf_adv   = buf_end && !last_buf;

  assign busy     = (state != ST_IDLE);
  assign rd_req   = (state == ST_FETCH);
  assign rd_addr  = desc_word_addr(fptr, fidx);
  assign beat_req = (state == ST_RUN) && (remain != '0);
  assign irq      = (state == ST_DONE);

  logic [1:0]    side_mode [NSIDE];
  logic [AW-1:0] side_init [NSIDE];
  logic [AW-1:0] side_cur  [NSIDE];
  assign side_mode[0] = msrc;
  assign side_mode[1] = mdst;
  assign side_init[0] = src0;
  assign side_init[1] = dst0;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_side #(.AW(AW), .STEP(BEAT_BYTES)) u_side (
      .clk(clk), .rst_n(rst_n), .mode(side_mode[g]), .init_addr(side_init[g]),
      .load_init(start), .desc_hit(rd_fire && (fidx == FIW'(g))),
      .desc_word(rd_data), .step(beat_fire), .buf_adv(buf_adv),
      .cur(side_cur[g])
    );
  end

  assign beat_src = side_cur[0];
  assign beat_dst = side_cur[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fidx      <= '0;
      remain    <= '0;
      bufs_done <= '0;
      fptr      <= '0;
      d_next    <= '0;
      d_last    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          bufs_done <= '0;
          remain    <= len0;
          fptr      <= dptr0;
          fidx      <= '0;
          d_last    <= 1'b0;
          d_next    <= '0;
          state     <= chain_any ? ST_FETCH : ST_RUN;
        end
        ST_FETCH: if (rd_fire) begin
          fidx <= fidx + 1'b1;
          if (fidx == FIW'(2)) begin
            remain <= rd_data[LW-1:0];
            d_last <= rd_data[AW-1];
          end
          if (fidx == FIW'(3)) begin
            d_next <= rd_data;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (remain == '0)   state  <= ST_NEXT;
          else if (beat_fire) remain <= remain - 1'b1;
        end
        ST_NEXT: begin
          bufs_done <= bufs_done + 1'b1;
          if (last_buf) state <= ST_DONE;
          else begin
            remain <= len0;
            if (chain_any) begin
              fptr  <= d_next;
              fidx  <= '0;
              state <= ST_FETCH;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !beat_req && !rd_req && !irq); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R2

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_req && !beat_ack) |=> beat_req && $stable(beat_src) && $stable(beat_dst)); // R4

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_req) |=> !beat_req || (beat_src == $past(beat_src) + AW'(BEAT_BYTES))); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req && $stable(rd_addr)); // R8

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && beat_req)); // R8

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq && !busy); // R11

endmodule

// File: tb/tb_dma_chain_seq.sv
module tb_dma_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n, cfg_we, rd_ack, beat_ack;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, rd_data;
  logic        busy, rd_req, beat_req, irq;
  logic [31:0] rd_addr, beat_src, beat_dst;

  always #10 clk = ~clk;

  dma_chain_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .beat_req(beat_req), .beat_src(beat_src), .beat_dst(beat_dst), .beat_ack(beat_ack),
    .irq(irq)
  );

  int n_vec = 0, n_bad = 0, irq_cnt = 0, cyc = 0;
  logic [31:0] mem [int];
  logic [31:0] exp_rd[$], exp_bs[$], exp_bd[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  // responder and per-clock comparison
  initial begin
    logic [31:0] e, f;
    beat_ack = 1'b0; rd_ack = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        chk(!(beat_req && rd_req), "R8", "rd_req and beat_req together", 1, 0);
        if (!busy) chk(!beat_req && !rd_req && !irq, "R1", "activity while idle",
                       {beat_req, rd_req, irq}, 0);
        if (irq) irq_cnt++;
      end
      rd_ack = rd_req && (cyc % 3 != 2);
      rd_data = mem.exists(int'(rd_addr)) ? mem[int'(rd_addr)] : 32'h0;
      if (rd_ack) begin
        if (exp_rd.size() == 0) chk(0, "R8", "unexpected descriptor read", rd_addr, 0);
        else begin
          e = exp_rd.pop_front();
          chk(rd_addr == e, "R8", "descriptor read address", rd_addr, e);
        end
      end
      beat_ack = beat_req && (cyc % 4 != 1);
      if (beat_ack) begin
        if (exp_bs.size() == 0) chk(0, "R4", "unexpected beat", beat_src, 0);
        else begin
          e = exp_bs.pop_front();
          f = exp_bd.pop_front();
          chk(beat_src == e, "R4/R5/R6/R9", "beat source", beat_src, e);
          chk(beat_dst == f, "R4/R5/R6/R9", "beat destination", beat_dst, f);
        end
      end
      if (cyc > 150000) begin
        chk(0, "watchdog", "run did not finish", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input logic [31:0] s, d, input int len, input logic [31:0] ptr,
                      input int ms, md, nb);
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, len); wr(3'd3, ptr);
    wr(3'd4, (nb << 8) | (md << 2) | ms);
  endtask

  // behavioural expectation of a whole transfer
  task automatic expect_xfer(input logic [31:0] s, d, input int len, input logic [31:0] ptr,
                             input int ms, md, nb);
    logic [31:0] cs = s, cd = d, p = ptr, w2, w3;
    bit chained = (ms == 2) || (md == 2);
    int nbufs = (nb == 0) ? 1 : nb;
    int b = 0;
    int blen;
    bit fin = 0;
    while (!fin) begin
      blen = len;
      if (chained) begin
        for (int k = 0; k < 4; k++) exp_rd.push_back(p + 4 * k);
        if (ms == 2) cs = mem[int'(p)];
        if (md == 2) cd = mem[int'(p + 4)];
        w2 = mem[int'(p + 8)];
        w3 = mem[int'(p + 12)];
        blen = int'(w2[15:0]);
      end
      for (int i = 0; i < blen; i++) begin
        exp_bs.push_back(cs); exp_bd.push_back(cd);
        cs += 4; cd += 4;
      end
      b++;
      if (chained) begin
        fin = w2[31] || (w3 == 0);
        p = w3;
      end else fin = (b >= nbufs);
      if (ms == 1) cs = s;
      if (md == 1) cd = d;
    end
  endtask

  task automatic go(input string tag);
    int w = 0;
    irq_cnt = 0;
    wr(3'd5, 32'h1);
    chk(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
    while (busy && w < 5000) begin @(negedge clk); w++; end
    @(negedge clk);
    chk(busy == 1'b0, "R2", {tag, " busy clears"}, busy, 0);
    chk(irq_cnt == 1, "R11", {tag, " irq pulses"}, irq_cnt, 1);
    chk(exp_bs.size() == 0, tag, "beats left unissued", exp_bs.size(), 0);
    chk(exp_rd.size() == 0, tag, "descriptor reads left unissued", exp_rd.size(), 0);
  endtask

  task automatic desc(input logic [31:0] at, s, d, ctrl, nxt);
    mem[int'(at)] = s; mem[int'(at + 4)] = d; mem[int'(at + 8)] = ctrl; mem[int'(at + 12)] = nxt;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    desc(32'h100, 32'h1000, 32'h2000, 32'd2, 32'h140);
    desc(32'h140, 32'h1800, 32'h2800, 32'd3, 32'h180);
    desc(32'h180, 32'h1900, 32'h2900, 32'd1, 32'h0);
    desc(32'h200, 32'h3000, 32'h3400, 32'h8000_0002, 32'h140);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, irq, beat_req, rd_req} == 4'b0, "R1", "reset outputs",
        {busy, irq, beat_req, rd_req}, 0);

    // R7 single-buffer with count 0
    prog(32'h4000, 32'h8000, 3, 0, 0, 0, 0);
    expect_xfer(32'h4000, 32'h8000, 3, 0, 0, 0, 0);
    go("R7 single");

    // R5 contiguous both sides, three buffers
    prog(32'h4100, 32'h8100, 2, 0, 0, 3, 3);
    expect_xfer(32'h4100, 32'h8100, 2, 0, 0, 3, 3);
    go("R5 contiguous");

    // R6 replay both sides
    prog(32'h4200, 32'h8200, 3, 0, 1, 1, 2);
    expect_xfer(32'h4200, 32'h8200, 3, 0, 1, 1, 2);
    go("R6 replay");

    // R9 independent: source replay, destination contiguous
    prog(32'h4300, 32'h8300, 2, 0, 1, 0, 3);
    expect_xfer(32'h4300, 32'h8300, 2, 0, 1, 0, 3);
    go("R9 replay/contig");

    // R8 R10 chain both sides, ends on zero next pointer
    prog(32'h0, 32'h0, 7, 32'h100, 2, 2, 0);
    expect_xfer(32'h0, 32'h0, 7, 32'h100, 2, 2, 0);
    go("R10 chain three");

    // R10 chain ends on last flag despite nonzero next
    prog(32'h0, 32'h0, 7, 32'h200, 2, 2, 5);
    expect_xfer(32'h0, 32'h0, 7, 32'h200, 2, 2, 5);
    go("R10 last flag");

    // R9 source chains, destination replays
    prog(32'h0, 32'h5000, 7, 32'h100, 2, 1, 0);
    expect_xfer(32'h0, 32'h5000, 7, 32'h100, 2, 1, 0);
    go("R9 chain/replay");

    // R9 source contiguous, destination chains
    prog(32'h6000, 32'h0, 7, 32'h140, 0, 2, 0);
    expect_xfer(32'h6000, 32'h0, 7, 32'h140, 0, 2, 0);
    go("R9 contig/chain");

    // R3 writes during busy are ignored, start included
    prog(32'h4400, 32'h8400, 4, 0, 0, 0, 3);
    expect_xfer(32'h4400, 32'h8400, 4, 0, 0, 0, 3);
    irq_cnt = 0;
    wr(3'd5, 32'h1);
    repeat (2) @(negedge clk);
    wr(3'd0, 32'h9990_0000);
    wr(3'd2, 32'd9);
    wr(3'd4, 32'h0000_0105);
    wr(3'd5, 32'h1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(irq_cnt == 1, "R3", "start while busy ignored", irq_cnt, 1);
    chk(exp_bs.size() == 0, "R3", "running transfer altered", exp_bs.size(), 0);
    expect_xfer(32'h4400, 32'h8400, 4, 0, 0, 0, 3);
    go("R3 rerun with original settings");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule